// File: doc/BRIEF.md
# Embedded Word-Boundary Serializer

This block turns 12-bit parallel words into a serial data line and sends a companion bit clock with it. Each word becomes a 14-bit frame. Bits 1 to 12 are the word itself. Bit 13 is the inverse of bit 12 and bit 14 is a copy of bit 12. The bit clock marks the end of a word by leaving out one low pulse, during bit 14. Because of the two guard bits, the data line always changes while the clock is held high at that boundary. A receiver finds word edges from the clock gap alone.

The block runs from one internal clock at twice the bit rate. Every bit lasts two cycles: a first half with the bit clock low and a second half with it high. Data changes only at the start of a bit, so data and clock are edge aligned. A rising edge on the strobe input copies the parallel word into a one-entry holding register. At the start of every frame slot, the frame controller takes a waiting word from that register. If no word is waiting, it sends an idle slot: zero data with a normal, gap-free clock.

An optional overclocked framing adds two zero bits to every third slot. The extra bits have normal clock pulses. The `ser_oe` output lets a wrapper tri-state the serial pins.

The controller has four states:
- `ST_OFF`: reset or power-down.
- `ST_WORD`: sending a word frame.
- `ST_FILL`: sending an idle slot.
- `ST_PAD`: sending the two trailing zero bits of a long slot.

The transitions are:
- **start**: from `ST_OFF` to `ST_WORD` or `ST_FILL`, on the first cycle out of reset.
- **next slot**: at the end of a slot, to `ST_WORD` if a word is waiting, otherwise to `ST_FILL`.
- **stretch**: from `ST_WORD` or `ST_FILL` to `ST_PAD`, at the end of a long slot.
- **pad done**: from `ST_PAD` to the next slot.
- **halt**: from any state to `ST_OFF`, on reset or power-down.

Top module: `word_boundary_ser`

## Requirements
- R1: In a word frame, serial bit i (i = 1..12, bit 1 sent first after the boundary) carries `par_in[i-1]` as it was captured.
- R2: Serial bit 13 of a word frame is the inverse of `par_in[11]`, and bit 14 equals `par_in[11]`, so the data line toggles at the start of bit 14.
- R3: Each bit lasts two clock cycles. `ser_clk` is low in the first cycle of a bit and high in the second, except for bit 14 of a word frame, where it stays high for both cycles. `ser_data` changes only at the start of a bit.
- R4: A rising edge of `strobe`, sampled on `clk`, captures `par_in`. The captured word is sent in the slot that starts next.
- R5: A slot that starts while no word is waiting carries 14 zero bits with a normal clock (no gap).
- R6: With `overclk_en` high, slot n (counted from 0 after reset or power-down) is 16 bits long when n mod 3 = 2. Its last two bits are zero with normal clock pulses. With `overclk_en` low, every slot is 14 bits.
- R7: A second strobe edge before the waiting word is taken replaces that word. Only the later word is sent.
- R8: While `rst` or `pwr_dn` is high, `ser_data` is low, `ser_clk` is high, `ser_oe` is low, and any waiting word is discarded. The first slot after release is an idle slot.
- R9: `ser_oe` is high in every cycle outside reset and power-down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock, twice the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| pwr_dn | input | 1 | Power-down, active high; acts like reset |
| overclk_en | input | 1 | Selects the 14/14/16 slot pattern |
| strobe | input | 1 | Word strobe; its rising edge captures `par_in` |
| par_in | input | 12 | Parallel word |
| ser_data | output | 1 | Serial data |
| ser_clk | output | 1 | Bit clock with the embedded word gap |
| ser_oe | output | 1 | Output-enable for the serial pins |

## Verification
The assertions assume that `strobe` and `par_in` are synchronous to `clk` and change away from its rising edge. They also assume that `overclk_en` changes only while the block is held in reset or power-down. The bench drives every input on the falling clock edge. It places strobe pulses in the middle of a slot, well clear of the slot-start cycle, and changes the framing mode only across a power-down. Under these conditions, the exact cycle of every output bit is known ahead of time.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WORD = 2'd1,
        ST_FILL = 2'd2,
        ST_PAD  = 2'd3
    } wbs_state_e;

    localparam int WBS_GUARD_BITS = 2;
endpackage

// File: rtl/wbs_hold.sv
module wbs_hold #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              halt,
    input  logic              strobe,
    input  logic [WORD_W-1:0] par_in,
    input  logic              accept,
    output logic              word_v,
    output logic [WORD_W-1:0] word
);
    logic strobe_q;
    logic rise;

    assign rise = strobe & ~strobe_q;

    always_ff @(posedge clk) begin
        strobe_q <= strobe;
        if (halt) begin
            word_v <= 1'b0;
            word   <= '0;
        end else if (rise) begin
            word_v <= 1'b1;
            word   <= par_in;
        end else if (accept) begin
            word_v <= 1'b0;
        end
    end

    AST_RISE_CAPTURES: assert property (@(posedge clk) disable iff (halt)
        rise |=> (word_v && word == $past(par_in))); // R4
    AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (halt)
        (accept && !rise) |=> !word_v); // R7
endmodule

// File: rtl/wbs_framer.sv
module wbs_framer
    import wbs_pkg::*;
#(
    parameter int WORD_W     = 12,
    parameter int PAD_BITS   = 2,
    parameter int LONG_EVERY = 3
) (
    input  logic              clk,
    input  logic              halt,
    input  logic              overclk,
    input  logic              word_v,
    input  logic [WORD_W-1:0] word,
    output logic              accept,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              ser_oe
);
    localparam int FRAME_W = WORD_W + WBS_GUARD_BITS;
    localparam int CNT_W   = $clog2(FRAME_W + PAD_BITS);
    localparam int FC_W    = (LONG_EVERY > 2) ? $clog2(LONG_EVERY) : 1;

    wbs_state_e         state, state_d;
    logic               phase;
    logic [CNT_W-1:0]   bitcnt;
    logic [FC_W-1:0]    frame_cnt;
    logic [FRAME_W-1:0] shreg;
    logic [FRAME_W-1:0] frame_vec;
    logic [CNT_W-1:0]   last_bit;
    logic               slot_end, long_slot, go_pad, new_slot;

    assign frame_vec = {word[WORD_W-1], ~word[WORD_W-1], word};

    always_comb begin
        last_bit  = (state == ST_PAD) ? CNT_W'(PAD_BITS - 1) : CNT_W'(FRAME_W - 1);
        slot_end  = (state != ST_OFF) && phase && (bitcnt == last_bit);
        long_slot = overclk && (frame_cnt == FC_W'(LONG_EVERY - 1));
        go_pad    = slot_end && (state != ST_PAD) && long_slot;
        new_slot  = (state == ST_OFF) || (slot_end && !go_pad);
        accept    = new_slot && word_v && !halt;
        state_d   = state;
        unique case (state)
            ST_OFF:          state_d = word_v ? ST_WORD : ST_FILL;
            ST_WORD, ST_FILL: begin
                if (go_pad)        state_d = ST_PAD;
                else if (slot_end) state_d = word_v ? ST_WORD : ST_FILL;
            end
            ST_PAD:          if (slot_end) state_d = word_v ? ST_WORD : ST_FILL;
            default:         state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (halt) begin
            state     <= ST_OFF;
            phase     <= 1'b0;
            bitcnt    <= '0;
            frame_cnt <= '0;
            shreg     <= '0;
        end else begin
            state <= state_d;
            phase <= (state == ST_OFF) ? 1'b0 : ~phase;
            if (new_slot || go_pad)
                bitcnt <= '0;
            else if (phase)
                bitcnt <= bitcnt + 1'b1;
            if (slot_end && !go_pad)
                frame_cnt <= (frame_cnt == FC_W'(LONG_EVERY - 1)) ? '0 : frame_cnt + 1'b1;
            if (accept)
                shreg <= frame_vec;
            else if (phase && state == ST_WORD)
                shreg <= shreg >> 1;
        end
    end

    always_comb begin
        ser_oe   = (state != ST_OFF);
        ser_data = (state == ST_WORD) && shreg[0];
        ser_clk  = (state == ST_OFF) || phase ||
                   ((state == ST_WORD) && (bitcnt == CNT_W'(FRAME_W - 1)));
    end

    AST_LOW_ONE_CYCLE: assert property (@(posedge clk) disable iff (halt)
        !ser_clk |=> ser_clk); // R3
    AST_DATA_HOLDS_IN_BIT: assert property (@(posedge clk) disable iff (halt)
        phase |-> $stable(ser_data)); // R3
    AST_GUARD_TOGGLE: assert property (@(posedge clk) disable iff (halt)
        (state == ST_WORD && bitcnt == CNT_W'(FRAME_W - 1) && !phase)
        |-> (ser_data != $past(ser_data))); // R2
    AST_PAD_ONLY_LONG: assert property (@(posedge clk) disable iff (halt)
        (state == ST_PAD) |-> (overclk && frame_cnt == FC_W'(LONG_EVERY - 1))); // R6
    AST_HALT_QUIET: assert property (@(posedge clk)
        halt |=> (!ser_oe && ser_clk && !ser_data)); // R8
endmodule

// File: rtl/word_boundary_ser.sv
module word_boundary_ser #(
    parameter int WORD_W     = 12,
    parameter int PAD_BITS   = 2,
    parameter int LONG_EVERY = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_dn,
    input  logic              overclk_en,
    input  logic              strobe,
    input  logic [WORD_W-1:0] par_in,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              ser_oe
);
    logic              halt;
    logic              accept;
    logic              word_v;
    logic [WORD_W-1:0] word;

    assign halt = rst | pwr_dn;

    wbs_hold #(.WORD_W(WORD_W)) u_hold (
        .clk    (clk),
        .halt   (halt),
        .strobe (strobe),
        .par_in (par_in),
        .accept (accept),
        .word_v (word_v),
        .word   (word)
    );

    wbs_framer #(
        .WORD_W     (WORD_W),
        .PAD_BITS   (PAD_BITS),
        .LONG_EVERY (LONG_EVERY)
    ) u_framer (
        .clk      (clk),
        .halt     (halt),
        .overclk  (overclk_en),
        .word_v   (word_v),
        .word     (word),
        .accept   (accept),
        .ser_data (ser_data),
        .ser_clk  (ser_clk),
        .ser_oe   (ser_oe)
    );
endmodule

// File: tb/word_boundary_ser_bench.sv
module word_boundary_ser_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_dn = 1'b0;
    logic        overclk_en = 1'b0;
    logic        strobe = 1'b0;
    logic [11:0] par_in = '0;
    logic        ser_data, ser_clk, ser_oe;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    word_boundary_ser u_word_boundary_ser (
        .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .overclk_en(overclk_en),
        .strobe(strobe), .par_in(par_in),
        .ser_data(ser_data), .ser_clk(ser_clk), .ser_oe(ser_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [11:0] word_for(input int k);
        case (k)
            1: return 12'hFFF;
            2: return 12'h555;
            3: return 12'h000;
            4: return 12'h800;
            5: return 12'h7FF;
            6: return 12'hAAA;
            default: return 12'((k * 1187 + 12'h5A3) & 12'hFFF);
        endcase
    endfunction

    // Checks one slot, starting at the falling edge after its first cycle.
    task automatic run_slot(input bit long_slot, input bit is_word, input logic [11:0] w,
                            input bit load, input logic [11:0] nword,
                            input bit dbl, input logic [11:0] first_word);
        int len = long_slot ? 32 : 28;
        for (int c = 0; c < len; c++) begin
            int  i  = c / 2;
            bit  ph = bit'(c % 2);
            bit  ed, ek;
            string rq;
            @(negedge clk);
            if (is_word && i < 12)       begin ed = w[i];   rq = "R1 R4"; end
            else if (is_word && i == 12) begin ed = ~w[11]; rq = "R2"; end
            else if (is_word && i == 13) begin ed = w[11];  rq = "R2"; end
            else if (i >= 14)            begin ed = 1'b0;   rq = "R6"; end
            else                         begin ed = 1'b0;   rq = "R5"; end
            ek = ph | (is_word && i == 13);
            chk(ser_data == ed, rq, ser_data, ed);
            chk(ser_clk == ek, (i >= 14) ? "R6 clk" : (is_word ? "R3" : "R5 clk"), ser_clk, ek);
            chk(ser_oe == 1'b1, "R9", ser_oe, 1);
            if (load) begin
                if (c == 4)          begin par_in = dbl ? first_word : nword; strobe = 1'b1; end
                if (c == 8)          strobe = 1'b0;
                if (dbl && c == 12)  begin par_in = nword; strobe = 1'b1; end
                if (dbl && c == 16)  strobe = 1'b0;
                if (c == 20)         par_in = ~nword;
            end
        end
    endtask

    task automatic run_phase(input bit oc, input int nslots, input int seed, input bit dbl_test);
        bit          cur_word = 1'b0;
        logic [11:0] cur_w = '0;
        for (int s = 0; s < nslots; s++) begin
            bit          ld = ((s + seed) % 5) != 3;
            logic [11:0] nw = word_for(s + 1 + seed);
            bit          dbl = dbl_test && (s % 7 == 2);
            run_slot(oc && (s % 3 == 2), cur_word, cur_w, ld, nw, dbl, ~nw);
            cur_word = ld;
            cur_w = nw;
        end
    endtask

    task automatic halt_check(input string rq);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(ser_data == 1'b0, rq, ser_data, 0);
            chk(ser_clk == 1'b1, rq, ser_clk, 1);
            chk(ser_oe == 1'b0, rq, ser_oe, 0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        halt_check("R8 reset");
        @(negedge clk);
        rst = 1'b0;
        // Standard framing: every slot is 14 bits, first slot idle (R5, R8).
        run_phase(1'b0, 200, 0, 1'b0);

        // Power-down with a word waiting: it must be dropped (R8).
        @(negedge clk);
        par_in = 12'hF0F; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        pwr_dn = 1'b1;
        halt_check("R8 pwr_dn");
        overclk_en = 1'b1;
        @(negedge clk);
        pwr_dn = 1'b0;
        // Overclocked framing, plus back-to-back strobes that overwrite (R6, R7).
        run_phase(1'b1, 150, 2, 1'b1);

        // Standard framing again after a power-down, with overwrites (R7).
        @(negedge clk);
        pwr_dn = 1'b1;
        halt_check("R8 pwr_dn");
        overclk_en = 1'b0;
        @(negedge clk);
        pwr_dn = 1'b0;
        run_phase(1'b0, 60, 4, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule